// File: doc/BRIEF.md
# Programming Mode Entry Sequencer

This block decides when the device may enter in-system programming mode and when it must leave it. It watches a power-on-reset level, the active-low external reset pin, the active-low slave-select pin and the programming-enable fuse. It drives an `isp_active` level that enables the programming interface, and a sticky `reentry_blocked` flag that keeps any further session from starting until the next power-on reset.

Entry is always possible in the cycle in which power-on reset ends. The conditions are that slave-select is a clean low and the reset pin is still held low. With the fuse set, entry is also possible in any later reset period, which is any time the reset pin is low with slave-select low. Once a session is running, it lasts until the reset pin is released. The end of a session arms the block-out flag. Only a new power-on reset clears that flag. The reset pin and slave-select each pass through a synchronizer chain of `SYNC_STAGES` flops before they are used.

Top module: `isp_entry_seq`

## Requirements
- R1: While `por` is high, `isp_active` and `reentry_blocked` are both 0 at every clock edge.
- R2: In the first clock edge after `por` falls, the block sets `isp_active` to 1 when the synchronized `ss_n` is 0 and the synchronized `rst_pin_n` is 0. The fuse value has no effect on this.
- R3: An `ss_n` level that is high, or anything other than a clean 0 (unknown or floating), counts as no request. With such a level the block never enters programming mode.
- R4: With `fuse_isp_en` = 1, the block is idle and `reentry_blocked` = 0. If `rst_pin_n` and `ss_n` both go low, `isp_active` rises on the third rising clock edge after the change, and not before.
- R5: With `fuse_isp_en` = 0, entry happens only at the end of power-on reset. A reset period later in the same power cycle leaves `isp_active` at 0.
- R6: While a session is active and `rst_pin_n` stays low, `isp_active` stays 1. Changes on `ss_n` have no effect.
- R7: After `rst_pin_n` goes high during a session, `isp_active` falls on the third rising clock edge and not before. `reentry_blocked` becomes 1 on that same edge.
- R8: `reentry_blocked` stays 1 until `por` is asserted. While it is set, no reset period starts a session, even with the fuse set.
- R9: If `por` ends while the reset pin is already released, no session starts and `reentry_blocked` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset in progress, active high, synchronous |
| rst_pin_n | input | 1 | External reset pin, low = reset period, asynchronous |
| ss_n | input | 1 | Slave-select pin, low = programming request, asynchronous |
| fuse_isp_en | input | 1 | Programming-enable fuse, 1 = entry in any reset period |
| isp_active | output | 1 | Programming mode is active |
| reentry_blocked | output | 1 | A session has ended in this power cycle |

## Verification
Two things can fall in the same cycle: the end-of-power-on-reset sample that grants entry, and the release of the reset pin that ends a session. The bench provokes this by releasing `por` while `rst_pin_n` is already high and `ss_n` is low, under both fuse values. It then checks that no session opens and that `reentry_blocked` stays clear. A pulse of `isp_active` would arm the flag, so a clear flag also shows that no one-cycle session took place. The bench also times both entry and exit against the synchronizer depth. It then checks that the exit edge and the setting of the block-out flag coincide.

// File: rtl/isp_entry_seq.sv
module isp_entry_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por,
  input  logic rst_pin_n,
  input  logic ss_n,
  input  logic fuse_isp_en,
  output logic isp_active,
  output logic reentry_blocked
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] rst_sh;
  logic [MSB:0] ss_sh;
  logic         por_d;
  logic         ss_req_raw;
  logic         rst_s;
  logic         ss_s;
  logic         por_fall;
  logic         enter;
  logic         leave;

  // only a clean low counts as a request; X or Z reads as no request
  assign ss_req_raw = (ss_n === 1'b0);

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        rst_sh <= {rst_sh[MSB-1:0], rst_pin_n};
        ss_sh  <= {ss_sh[MSB-1:0], ss_req_raw};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        rst_sh <= rst_pin_n;
        ss_sh  <= ss_req_raw;
      end
    end
  endgenerate

  always_ff @(posedge clk) por_d <= por;

  assign rst_s    = rst_sh[MSB];
  assign ss_s     = ss_sh[MSB];
  assign por_fall = por_d & ~por;

  assign enter = ~isp_active & ~reentry_blocked & ss_s & ~rst_s
               & (por_fall | fuse_isp_en);
  assign leave = isp_active & rst_s;

  always_ff @(posedge clk) begin
    if (por) begin
      isp_active      <= 1'b0;
      reentry_blocked <= 1'b0;
    end else if (enter) begin
      isp_active      <= 1'b1;
    end else if (leave) begin
      isp_active      <= 1'b0;
      reentry_blocked <= 1'b1;
    end
  end

endmodule

module isp_entry_seq_chk (
  input logic clk,
  input logic por,
  input logic por_d,
  input logic rst_s,
  input logic fuse_isp_en,
  input logic isp_active,
  input logic reentry_blocked
);

  // R1
  por_clear_chk: assert property (@(posedge clk)
    por |=> (!isp_active && !reentry_blocked));

  // R7
  flag_on_exit_chk: assert property (@(posedge clk) disable iff (por)
    $fell(isp_active) |-> reentry_blocked);

  // R7
  exit_chk: assert property (@(posedge clk) disable iff (por)
    (isp_active && rst_s) |=> !isp_active);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (por)
    (isp_active && !rst_s) |=> isp_active);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (por)
    reentry_blocked |=> reentry_blocked);

  // R8
  no_reentry_chk: assert property (@(posedge clk) disable iff (por)
    (reentry_blocked && !isp_active) |=> !isp_active);

  // R5
  fuse_off_chk: assert property (@(posedge clk) disable iff (por)
    (!fuse_isp_en && !isp_active && !por_d) |=> !isp_active);

endmodule

bind isp_entry_seq isp_entry_seq_chk u_chk (
  .clk(clk),
  .por(por),
  .por_d(por_d),
  .rst_s(rst_s),
  .fuse_isp_en(fuse_isp_en),
  .isp_active(isp_active),
  .reentry_blocked(reentry_blocked)
);

// File: tb/isp_entry_seq_tb.sv
module isp_entry_seq_tb;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic rst_pin_n = 1'b0;
  logic ss_n = 1'b1;
  logic fuse_isp_en = 1'b0;
  logic isp_active;
  logic reentry_blocked;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  isp_entry_seq u_dut (
    .clk(clk),
    .por(por),
    .rst_pin_n(rst_pin_n),
    .ss_n(ss_n),
    .fuse_isp_en(fuse_isp_en),
    .isp_active(isp_active),
    .reentry_blocked(reentry_blocked)
  );

  // {fuse, ss_n, rst_pin_n, expected isp_active} at the end of power-on reset
  localparam logic [3:0] VEC [0:5] = '{
    4'b0001, 4'b0100, 4'b1001, 4'b1100, 4'b0010, 4'b1010
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_por(input logic f, input logic s, input logic r);
    @(negedge clk);
    por = 1'b1; fuse_isp_en = f; ss_n = s; rst_pin_n = r;
    repeat (4) @(negedge clk);
    chk("R1 active during por", isp_active, 1'b0);
    chk("R1 blocked during por", reentry_blocked, 1'b0);
    por = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset active", isp_active, 1'b0);
    chk("R1 reset blocked", reentry_blocked, 1'b0);

    for (int i = 0; i < 6; i++) begin
      do_por(VEC[i][3], VEC[i][2], VEC[i][1]);
      if (VEC[i][1])
        chk("R9 por end with reset released", isp_active, VEC[i][0]);
      else if (VEC[i][2])
        chk("R3 ss high no entry", isp_active, VEC[i][0]);
      else
        chk("R2 entry at por end", isp_active, VEC[i][0]);
      if (VEC[i][1]) chk("R9 blocked stays clear", reentry_blocked, 1'b0);
    end

    // session at por with fuse cleared, ss ignored, timed exit
    do_por(1'b0, 1'b0, 1'b0);
    chk("R2 entry fuse off", isp_active, 1'b1);
    ss_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 ss change ignored", isp_active, 1'b1);
    rst_pin_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 still active before third edge", isp_active, 1'b1);
    chk("R7 blocked not yet set", reentry_blocked, 1'b0);
    @(negedge clk);
    chk("R7 exit on third edge", isp_active, 1'b0);
    chk("R7 blocked set with exit", reentry_blocked, 1'b1);

    // locked out even with fuse set
    fuse_isp_en = 1'b1; rst_pin_n = 1'b0; ss_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 no reentry", isp_active, 1'b0);
    chk("R8 blocked sticky", reentry_blocked, 1'b1);

    // por clears the lockout; no session this time
    do_por(1'b0, 1'b1, 1'b1);
    chk("R8 por clears blocked", reentry_blocked, 1'b0);
    chk("R9 no session", isp_active, 1'b0);

    // fuse cleared: later reset period does not enter
    rst_pin_n = 1'b0; ss_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R5 no late entry with fuse off", isp_active, 1'b0);
    rst_pin_n = 1'b1; ss_n = 1'b1;
    repeat (4) @(negedge clk);

    // fuse set: timed late entry
    fuse_isp_en = 1'b1;
    @(negedge clk);
    rst_pin_n = 1'b0; ss_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 not yet active", isp_active, 1'b0);
    @(negedge clk);
    chk("R4 active on third edge", isp_active, 1'b1);
    rst_pin_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 late session exit", isp_active, 1'b0);
    chk("R7 late session blocked", reentry_blocked, 1'b1);

    // fuse set, ss high in reset period: no entry after new por
    do_por(1'b1, 1'b1, 1'b1);
    rst_pin_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R3 ss high late no entry", isp_active, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule